// File: doc/BRIEF.md
# Photon-Counting Pixel Column with Serial Shift Readout

This block models one column of a hybrid pixel detector readout chip. Every pixel owns a digital hit counter. While the column is in counting mode, a counter advances by one on each clock cycle in which that pixel's comparator strobe is high. The counter stops at all ones instead of wrapping. A synchronous clear zeroes every counter before an acquisition starts.

In readout mode the same counter registers are reused as shift-register stages. They are chained end to end, so the whole column behaves as one long shift register of `NPIX*CW` bits. The serial output is presented as a stream. `sout_valid` is high whenever the column is in readout mode, and `sout_data` shows the current bit. The consumer takes a bit by raising `sout_ready`. This acts as the externally supplied shift clock enable; the block never advances the shift path on its own. While `sout_ready` is low the stream is back-pressured: the presented bit and all stored state hold unchanged. On each accepted shift the bit on `sin` enters the far end of the chain.

Pixel 0 is the pixel next to the output. Its MSB leaves first, then the rest of its bits in falling significance, then pixel 1, and so on. The column length and the counter width are parameters.

Top module: `pixcol_top`

## Requirements
- R1: After asynchronous reset, every counter holds zero, so a full readout of `NPIX*CW` bits yields only zeros.
- R2: With `mode_rd` = 0, each clock cycle with `hit[i]` = 1 increments pixel i's counter by exactly one.
- R3: A counter that holds all ones (2^CW-1) stays at all ones on further hits; it never wraps.
- R4: With `mode_rd` = 1, `sout_data` is the MSB of pixel 0. The stream order is MSB first within a pixel, and pixel 0 comes first, then pixel 1, up to pixel NPIX-1.
- R5: A shift happens only on a cycle with `mode_rd` = 1 and `sout_ready` = 1. When `sout_ready` = 0, `sout_data` and the stored counts are unchanged.
- R6: Each accepted shift loads `sin` into the LSB of pixel NPIX-1. After `NPIX*CW` shifts, the bits fed in come out in the same order.
- R7: Hit strobes have no effect while `mode_rd` = 1.
- R8: `sout_ready` has no effect while `mode_rd` = 0.
- R9: `clr` = 1 zeroes all counters at the next clock edge. It takes priority over hits and shifts.
- R10: `sout_valid` equals `mode_rd` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| mode_rd | input | 1 | 0 = counting, 1 = readout |
| hit | input | NPIX | Per-pixel comparator strobes |
| sin | input | 1 | Serial bit entering the chain tail |
| sout_ready | input | 1 | Consumer accepts the bit; shift enable |
| sout_valid | output | 1 | Serial bit is valid (readout mode) |
| sout_data | output | 1 | Serial bit from the column end |

## Verification
On every cycle the assertions check the following:
- that counters step by exactly one on a hit;
- that a saturated counter stays full;
- that the output bit holds under back-pressure and in counting mode when pixel 0 is idle;
- that each accepted shift brings the next bit of pixel 0 to the output;
- that a clear empties the output stage;
- that the valid flag follows the mode.

Only the bench scenarios can show the complete serial order across pixel boundaries and the sweep of hit counts through saturation. They also cover hits being discarded during readout, and serial input data returning after a full pass through the chain.

// File: rtl/pixcol_pkg.sv
package pixcol_pkg;
  typedef enum logic {
    MODE_COUNT = 1'b0,
    MODE_SHIFT = 1'b1
  } col_mode_e;

  typedef struct packed {
    logic count_en;
    logic shift_en;
    logic clear;
  } stage_ctl_t;
endpackage

// File: rtl/pixcol_mode_ctrl.sv
module pixcol_mode_ctrl
  import pixcol_pkg::*;
(
  input  logic       clr,
  input  logic       mode_rd,
  input  logic       sout_ready,
  output stage_ctl_t ctl,
  output logic       sout_valid
);
  col_mode_e mode;

  always_comb begin
    mode         = col_mode_e'(mode_rd);
    ctl.clear    = clr;
    ctl.count_en = (mode == MODE_COUNT) && !clr;
    ctl.shift_en = (mode == MODE_SHIFT) && sout_ready && !clr;
    sout_valid   = (mode == MODE_SHIFT);
  end
endmodule

// File: rtl/pixcol_cell.sv
module pixcol_cell
  import pixcol_pkg::*;
#(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stage_ctl_t    ctl,
  input  logic          hit,
  input  logic          ser_in,
  output logic [CW-1:0] cnt_q
);
  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ctl.clear)
      cnt_d = '0;
    else if (ctl.shift_en)
      cnt_d = {cnt_q[CW-2:0], ser_in};
    else if (ctl.count_en && hit && (cnt_q != FULL))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pixcol_top.sv
module pixcol_top
  import pixcol_pkg::*;
#(
  parameter int NPIX = 256,
  parameter int CW   = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            mode_rd,
  input  logic [NPIX-1:0] hit,
  input  logic            sin,
  input  logic            sout_ready,
  output logic            sout_valid,
  output logic            sout_data
);
  localparam int LAST = NPIX - 1;

  stage_ctl_t              ctl;
  logic [NPIX-1:0][CW-1:0] stage_q;
  logic [NPIX-1:0]         chain_in;

  pixcol_mode_ctrl u_ctrl (
    .clr        (clr),
    .mode_rd    (mode_rd),
    .sout_ready (sout_ready),
    .ctl        (ctl),
    .sout_valid (sout_valid)
  );

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    if (p == LAST) begin : g_tail
      assign chain_in[p] = sin;
    end else begin : g_link
      assign chain_in[p] = stage_q[p+1][CW-1];
    end
    pixcol_cell #(.CW(CW)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl    (ctl),
      .hit    (hit[p]),
      .ser_in (chain_in[p]),
      .cnt_q  (stage_q[p])
    );
  end

  assign sout_data = stage_q[0][CW-1];
endmodule

// File: rtl/pixcol_checker.sv
module pixcol_checker #(
  parameter int NPIX = 256,
  parameter int CW   = 14
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    clr,
  input logic                    mode_rd,
  input logic [NPIX-1:0]         hit,
  input logic                    sout_ready,
  input logic                    sout_valid,
  input logic                    sout_data,
  input logic [NPIX-1:0][CW-1:0] stage_q
);
  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  assert_valid_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sout_valid == mode_rd);

  assert_hold_backpressure_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd && !sout_ready && !clr) |=> $stable(sout_data));

  assert_count_mode_no_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_rd && !clr && !hit[0]) |=> $stable(sout_data));

  assert_shift_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd && sout_ready && !clr) |=> (sout_data == $past(stage_q[0][CW-2])));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stage_q[0] == '0 && stage_q[NPIX-1] == '0));

  for (genvar p = 0; p < NPIX; p++) begin : g_px
    assert_increment_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_rd && !clr && hit[p] && stage_q[p] != FULL)
        |=> (stage_q[p] == $past(stage_q[p]) + 1'b1));
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_rd && !clr && stage_q[p] == FULL) |=> (stage_q[p] == FULL));
    assert_readout_ignores_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_rd && !sout_ready && !clr) |=> $stable(stage_q[p]));
  end
endmodule

bind pixcol_top pixcol_checker #(.NPIX(NPIX), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .mode_rd    (mode_rd),
  .hit        (hit),
  .sout_ready (sout_ready),
  .sout_valid (sout_valid),
  .sout_data  (sout_data),
  .stage_q    (stage_q)
);

// File: tb/test_pixcol_top.sv
module test_pixcol_top;
  localparam int NPIX = 4;
  localparam int CW   = 4;
  localparam int NB   = NPIX * CW;
  localparam int SAT  = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, clr = 0, mode_rd = 0, sin = 0, sout_ready = 0;
  logic [NPIX-1:0] hit = '0;
  logic sout_valid, sout_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pixcol_top #(.NPIX(NPIX), .CW(CW)) i_pixcol_top (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode_rd(mode_rd), .hit(hit),
    .sin(sin), .sout_ready(sout_ready), .sout_valid(sout_valid), .sout_data(sout_data)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] expect_stream(input int cnt [NPIX]);
    logic [NB-1:0] s;
    for (int k = 0; k < NB; k++) begin
      int v = (cnt[k / CW] > SAT) ? SAT : cnt[k / CW];
      s[k] = v[CW - 1 - (k % CW)];
    end
    return s;
  endfunction

  task automatic count_hits(input int cnt [NPIX]);
    int mx = 0;
    mode_rd = 0;
    for (int i = 0; i < NPIX; i++) if (cnt[i] > mx) mx = cnt[i];
    for (int c = 0; c < mx; c++) begin
      for (int i = 0; i < NPIX; i++) hit[i] = (c < cnt[i]);
      sout_ready = c[0];   // R8: must not shift in counting mode
      sin = ~c[0];
      tick();
    end
    hit = '0; sout_ready = 0; sin = 0;
  endtask

  task automatic read_out(input logic [NB-1:0] exp, input logic [NB-1:0] feed,
                          input bit stall, input string req);
    mode_rd = 1;
    #1;
    check("R10 valid in readout", sout_valid, 1);
    for (int k = 0; k < NB; k++) begin
      if (stall && (k % 3 == 1)) begin
        logic held = sout_data;
        sout_ready = 0; hit = '1;   // R7 hits ignored, R5 hold
        tick();
        hit = '0;
        check("R5 hold under back-pressure", sout_data, held);
      end
      check(req, sout_data, exp[k]);
      sout_ready = 1; sin = feed[k];
      tick();
      sout_ready = 0; sin = 0;
    end
    mode_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c [NPIX];
    logic [NB-1:0] pat;
    tick(); tick();
    rst_n = 1;
    tick();
    check("R10 valid low in counting", sout_valid, 0);
    read_out('0, '0, 0, "R1 reset zeros");

    // R2/R3/R4/R5/R8: mixed counts including saturation
    c = '{3, 0, 9, 20};
    count_hits(c);
    read_out(expect_stream(c), '0, 1, "R4 stream order");

    // R7: hits during readout with ready low must not change counts
    c = '{5, 12, 1, 7};
    count_hits(c);
    mode_rd = 1; hit = '1;
    tick(); tick(); tick();
    hit = '0;
    read_out(expect_stream(c), '0, 0, "R7 hits ignored in readout");

    // R6: serial input returns after one full pass
    pat = 16'hB4E1;
    clr = 1; tick(); clr = 0;
    read_out('0, pat, 0, "R6 first pass zeros");
    read_out(pat, '0, 0, "R6 sin returns in order");

    // R9: clear with hits and shift requests asserted together
    c = '{6, 6, 6, 6};
    count_hits(c);
    clr = 1; hit = '1; sout_ready = 1; mode_rd = 0;
    tick();
    clr = 0; hit = '0; sout_ready = 0;
    read_out('0, '0, 0, "R9 clear priority");

    // R2/R3 sweep over counts through saturation
    for (int n = 0; n <= SAT + 3; n++) begin
      clr = 1; tick(); clr = 0;
      for (int i = 0; i < NPIX; i++) c[i] = n + i;
      count_hits(c);
      read_out(expect_stream(c), '0, (n % 4 == 0), "R2 R3 count sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule